// File: doc/BRIEF.md
# Low-Power Stop Announcement Sequencer

This block sits between a processor core and its external bus. When the core asks to enter low-power stop, the block first records the core's 3-bit interrupt mask level. It then waits until the external bus is free and runs one visible write cycle in CPU address space. The address identifies the cycle as the stop announcement, and the data word carries the mask level. Other devices on the bus can therefore see that the chip is about to stop and which interrupt levels will still wake it.

The block acknowledges the cycle itself, so no external responder is needed. After that acknowledge it raises a stop-entered flag. An external hold-off input can keep the block waiting before that flag rises, which gives slow peripherals time to get ready. Once the flag is raised, the block stays stopped until reset. Wake-up logic is outside this block.

Top module: `lpstop_bcast`

## Requirements
- R1: While reset is high, and on the first cycle after it, `as_o`, `ds_o`, `int_ack_o` and `stop_entered_o` are 0, `rw_o` is 1, and `fc_o`, `addr_o` and `data_o` are all zero.
- R2: A high `lp_req` in the idle state is accepted. `as_o` stays low for as long as `bus_free` is sampled low, and it rises on the cycle after the first clock edge at which `bus_free` is sampled high.
- R3: While `as_o` is high, `fc_o` is 3'b111 (CPU space), `addr_o[19:16]` is 4'h3, all other address bits are 0, and `rw_o` is 0 (write).
- R4: `ds_o` rises one cycle after `as_o` and stays high for two cycles. During those cycles `data_o[2:0]` and `data_o[18:16]` both carry the captured mask, and every other data bit is 0.
- R5: The mask is taken from `irq_mask` on the cycle the request is accepted. Later changes on `irq_mask` do not change the mask placed on the bus.
- R6: `int_ack_o` is high for exactly one cycle, on the second cycle of `ds_o`. No external acknowledge input exists.
- R7: The acknowledge edge samples `hold_off`. If it is high, `stop_entered_o` stays 0 for as long as `hold_off` stays high. `stop_entered_o` rises on the cycle after the first edge at which `hold_off` is sampled low.
- R8: Once `stop_entered_o` is 1, it stays 1 until reset. Further `lp_req` pulses start no new bus cycle.
- R9: After the acknowledge cycle, `as_o`, `ds_o`, `fc_o`, `addr_o` and `data_o` return to zero and `rw_o` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lp_req | input | 1 | Request from the core to enter low-power stop |
| irq_mask | input | 3 | Current interrupt mask level from the core |
| bus_free | input | 1 | The external bus is available to this master |
| hold_off | input | 1 | External request to delay stop entry |
| as_o | output | 1 | Address strobe, high while the address is valid |
| ds_o | output | 1 | Data strobe, high while the data is valid |
| rw_o | output | 1 | Transfer direction: 1 = read or idle, 0 = write |
| fc_o | output | 3 | Function code (address space) |
| addr_o | output | ADDR_W (24) | Address bus |
| data_o | output | DATA_W (32) | Data bus |
| int_ack_o | output | 1 | Internally generated cycle acknowledge |
| stop_entered_o | output | 1 | The device is now in low-power stop |

## Verification
The assertions check the following on every cycle:
- The CPU-space encoding holds whenever the address strobe is high.
- The two mask copies in the data word agree.
- The data stays stable across the data phase.
- The acknowledge is a single cycle that falls inside the data phase.
- The address strobe never rises without the bus having been free.
- Hold-off blocks stop entry.
- Stop entry is sticky.

Only the bench scenarios can show the rest:
- The exact mask value that appears for each of the eight levels.
- That a mask change after the request has no effect.
- The exact cycle on which each phase begins under different bus-wait and hold-off lengths.
- That requests made after stop are ignored.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;

    localparam int MASK_W       = 3;
    localparam int FC_W         = 3;
    localparam int TYPE_W       = 4;
    localparam int TYPE_LSB     = 16;
    localparam int NUM_LANES    = 2;
    localparam int LANE_STRIDE  = 16;

    localparam logic [FC_W-1:0]   FC_CPU_SPACE  = 3'b111;
    localparam logic [FC_W-1:0]   FC_NONE       = 3'b000;
    localparam logic [TYPE_W-1:0] CPU_TYPE_STOP = 4'h3;

    typedef logic [MASK_W-1:0] mask_t;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_BUS  = 3'd1,
        ST_ADDR      = 3'd2,
        ST_DATA      = 3'd3,
        ST_ACK       = 3'd4,
        ST_HOLD_HALT = 3'd5,
        ST_STOPPED   = 3'd6
    } seq_state_t;

    typedef struct packed {
        logic          addr_phase;
        logic          data_phase;
        logic          ack;
        logic          stopped;
    } phase_t;

    function automatic phase_t decode_phase(seq_state_t s);
        phase_t p;
        p.addr_phase = (s == ST_ADDR) || (s == ST_DATA) || (s == ST_ACK);
        p.data_phase = (s == ST_DATA) || (s == ST_ACK);
        p.ack        = (s == ST_ACK);
        p.stopped    = (s == ST_STOPPED);
        return p;
    endfunction

endpackage

// File: rtl/lpstop_mask_hold.sv
module lpstop_mask_hold
    import lpstop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  mask_t mask_in,
    output mask_t mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (load) begin
            mask_q <= mask_in;
        end
    end

endmodule

// File: rtl/lpstop_seq_fsm.sv
module lpstop_seq_fsm
    import lpstop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lp_req,
    input  logic       bus_free,
    input  logic       hold_off,
    output logic       accept,
    output seq_state_t state_q
);

    seq_state_t state_d;

    assign accept = (state_q == ST_IDLE) && lp_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (lp_req)    state_d = ST_WAIT_BUS;
            ST_WAIT_BUS:  if (bus_free)  state_d = ST_ADDR;
            ST_ADDR:                     state_d = ST_DATA;
            ST_DATA:                     state_d = ST_ACK;
            ST_ACK:       state_d = hold_off ? ST_HOLD_HALT : ST_STOPPED;
            ST_HOLD_HALT: if (!hold_off) state_d = ST_STOPPED;
            ST_STOPPED:                  state_d = ST_STOPPED;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/lpstop_bus_drive.sv
module lpstop_bus_drive
    import lpstop_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  seq_state_t        state_q,
    input  mask_t             mask_q,
    output logic              as_o,
    output logic              ds_o,
    output logic              rw_o,
    output logic [FC_W-1:0]   fc_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              int_ack_o,
    output logic              stop_entered_o
);

    localparam logic [ADDR_W-1:0] STOP_ADDR =
        {{(ADDR_W-TYPE_W){1'b0}}, CPU_TYPE_STOP} << TYPE_LSB;

    phase_t            ph;
    logic [DATA_W-1:0] lane_word [NUM_LANES];
    logic [DATA_W-1:0] mirror_word;

    assign ph = decode_phase(state_q);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_word[g] = {{(DATA_W-MASK_W){1'b0}}, mask_q} << (g*LANE_STRIDE);
    end

    always_comb begin
        mirror_word = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            mirror_word = mirror_word | lane_word[i];
        end
    end

    assign as_o           = ph.addr_phase;
    assign ds_o           = ph.data_phase;
    assign rw_o           = !ph.addr_phase;
    assign fc_o           = ph.addr_phase ? FC_CPU_SPACE : FC_NONE;
    assign addr_o         = ph.addr_phase ? STOP_ADDR : '0;
    assign data_o         = ph.data_phase ? mirror_word : '0;
    assign int_ack_o      = ph.ack;
    assign stop_entered_o = ph.stopped;

endmodule

// File: rtl/lpstop_bcast.sv
module lpstop_bcast
    import lpstop_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lp_req,
    input  logic [2:0]        irq_mask,
    input  logic              bus_free,
    input  logic              hold_off,
    output logic              as_o,
    output logic              ds_o,
    output logic              rw_o,
    output logic [2:0]        fc_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              int_ack_o,
    output logic              stop_entered_o
);

    seq_state_t state_q;
    logic       accept;
    mask_t      mask_q;

    lpstop_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .lp_req   (lp_req),
        .bus_free (bus_free),
        .hold_off (hold_off),
        .accept   (accept),
        .state_q  (state_q)
    );

    lpstop_mask_hold u_mask (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .mask_in (irq_mask),
        .mask_q  (mask_q)
    );

    lpstop_bus_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_drive (
        .state_q        (state_q),
        .mask_q         (mask_q),
        .as_o           (as_o),
        .ds_o           (ds_o),
        .rw_o           (rw_o),
        .fc_o           (fc_o),
        .addr_o         (addr_o),
        .data_o         (data_o),
        .int_ack_o      (int_ack_o),
        .stop_entered_o (stop_entered_o)
    );

endmodule

// File: rtl/lpstop_bcast_chk.sv
module lpstop_bcast_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              lp_req,
    input logic [2:0]        irq_mask,
    input logic              bus_free,
    input logic              hold_off,
    input logic              as_o,
    input logic              ds_o,
    input logic              rw_o,
    input logic [2:0]        fc_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [DATA_W-1:0] data_o,
    input logic              int_ack_o,
    input logic              stop_entered_o
);

    logic [ADDR_W-1:0] addr_rest;
    always_comb begin
        addr_rest = addr_o;
        addr_rest[19:16] = 4'h0;
    end

    assert_start_needs_bus_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(as_o) |-> $past(bus_free));

    assert_cpu_space_R3: assert property (@(posedge clk) disable iff (rst)
        as_o |-> (fc_o == 3'b111) && (addr_o[19:16] == 4'h3) && (addr_rest == '0) && !rw_o);

    assert_mask_mirror_R4: assert property (@(posedge clk) disable iff (rst)
        ds_o |-> (data_o[2:0] == data_o[18:16]) && as_o);

    assert_data_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (ds_o && $past(ds_o)) |-> $stable(data_o));

    assert_ack_single_R6: assert property (@(posedge clk) disable iff (rst)
        int_ack_o |=> !int_ack_o);

    assert_ack_in_data_R6: assert property (@(posedge clk) disable iff (rst)
        int_ack_o |-> ds_o && $past(ds_o));

    assert_hold_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (hold_off && !stop_entered_o) |=> !stop_entered_o);

    assert_stop_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        stop_entered_o |=> stop_entered_o);

    assert_quiet_when_stopped_R9: assert property (@(posedge clk) disable iff (rst)
        stop_entered_o |-> !as_o && !ds_o && rw_o && (data_o == '0) && (addr_o == '0));

    logic unused_ok;
    assign unused_ok = ^{lp_req, irq_mask};

endmodule

bind lpstop_bcast lpstop_bcast_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .lp_req         (lp_req),
    .irq_mask       (irq_mask),
    .bus_free       (bus_free),
    .hold_off       (hold_off),
    .as_o           (as_o),
    .ds_o           (ds_o),
    .rw_o           (rw_o),
    .fc_o           (fc_o),
    .addr_o         (addr_o),
    .data_o         (data_o),
    .int_ack_o      (int_ack_o),
    .stop_entered_o (stop_entered_o)
);

// File: tb/lpstop_bcast_tb_top.sv
module lpstop_bcast_tb_top;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              lp_req;
    logic [2:0]        irq_mask;
    logic              bus_free;
    logic              hold_off;
    logic              as_o, ds_o, rw_o;
    logic [2:0]        fc_o;
    logic [ADDR_W-1:0] addr_o;
    logic [DATA_W-1:0] data_o;
    logic              int_ack_o;
    logic              stop_entered_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    lpstop_bcast #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .lp_req(lp_req), .irq_mask(irq_mask),
        .bus_free(bus_free), .hold_off(hold_off), .as_o(as_o), .ds_o(ds_o),
        .rw_o(rw_o), .fc_o(fc_o), .addr_o(addr_o), .data_o(data_o),
        .int_ack_o(int_ack_o), .stop_entered_o(stop_entered_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] exp_data(input int m);
        return DATA_W'(m) + (DATA_W'(m) * 65536);
    endfunction

    task automatic idle_outputs(input string req);
        check(!as_o && !ds_o && rw_o && !int_ack_o, {req, " strobes"},
              {as_o, ds_o, rw_o, int_ack_o}, 4'b0010);
        check(fc_o == 3'd0 && addr_o == '0 && data_o == '0, {req, " buses"},
              {fc_o, addr_o, data_o}, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1; lp_req = 1'b0; irq_mask = 3'd0; bus_free = 1'b0; hold_off = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        idle_outputs("R1 in reset");
        check(!stop_entered_o, "R1 stop", stop_entered_o, 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        idle_outputs("R1 after reset");
    endtask

    task automatic run_case(input int m, input int bus_wait, input int halt_len);
        do_reset();
        lp_req = 1'b1; irq_mask = 3'(m); hold_off = (halt_len > 0);
        @(posedge clk); @(negedge clk);
        lp_req = 1'b0; irq_mask = ~3'(m);
        check(!as_o, "R2 no strobe before bus", as_o, 0);
        for (int i = 0; i < bus_wait; i++) begin
            @(posedge clk); @(negedge clk);
            check(!as_o, "R2 waiting for bus", as_o, 0);
        end
        bus_free = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_free = 1'b0;
        check(as_o && !ds_o && !rw_o, "R2 address phase", {as_o, ds_o, rw_o}, 3'b100);
        check(fc_o == 3'b111, "R3 function code", fc_o, 3'b111);
        check(addr_o == 24'h03_0000, "R3 address", addr_o, 24'h03_0000);
        check(!int_ack_o, "R6 no early ack", int_ack_o, 0);
        @(posedge clk); @(negedge clk);
        check(as_o && ds_o, "R4 data strobe", {as_o, ds_o}, 2'b11);
        check(data_o == exp_data(m), "R4 R5 data word", data_o, exp_data(m));
        check(!int_ack_o, "R6 ack not in first data cycle", int_ack_o, 0);
        @(posedge clk); @(negedge clk);
        check(ds_o && int_ack_o, "R6 ack cycle", {ds_o, int_ack_o}, 2'b11);
        check(data_o == exp_data(m), "R5 data held", data_o, exp_data(m));
        check(!stop_entered_o, "R7 not stopped at ack", stop_entered_o, 0);
        for (int i = 0; i < halt_len; i++) begin
            @(posedge clk); @(negedge clk);
            check(!stop_entered_o, "R7 held off", stop_entered_o, 0);
            idle_outputs("R9 released during hold");
            if (i == halt_len - 1) hold_off = 1'b0;
        end
        @(posedge clk); @(negedge clk);
        check(stop_entered_o, "R7 stop entered", stop_entered_o, 1);
        idle_outputs("R9 released");
        lp_req = 1'b1; bus_free = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
            check(stop_entered_o && !as_o, "R8 sticky and ignores request", {stop_entered_o, as_o}, 2'b10);
        end
        lp_req = 1'b0; bus_free = 1'b0;
    endtask

    initial begin
        for (int m = 0; m < 8; m++) begin
            for (int w = 0; w < 3; w += 2) begin
                for (int h = 0; h < 4; h += 1 + (h == 1 ? 1 : 0)) begin
                    run_case(m, w, h);
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule